// File: doc/BRIEF.md
# NAND Page ECC Status Checker

This block decides the fate of one NAND page after the flash controller has finished reading it into its page buffer. The caller names the buffer slot and pulses `start`. The checker then polls the controller's event status word until the operation-complete bit comes up. If the flash-timeout bit is also set, the checker stops with a fatal timeout error and does not look at the ECC status.

Otherwise it walks through the sub-buffer error counts that belong to the page. A page is cut into 512-byte sub-buffers by default, and four counts are packed into each 32-bit status word. A count of 0xF marks a sub-buffer as uncorrectable. In that case the checker reads the whole page back one byte per cycle. A page that is entirely 0xFF is an erased page: it is reported as blank and no further sub-buffers are checked. Any other byte value raises a sticky fatal ECC error.

When the walk ends normally, the checker pulses `done` with a good or blank verdict. In the same cycle it writes the captured event value back, which clears the set bits. The checker does not correct data and does not compute ECC.

Top module: `nand_page_ecc_check`

States:
- `ST_IDLE`: waits for `start`.
- `ST_POLL`: waits on the event word. It goes to `ST_HALT` on a timeout and to `ST_ECC` on a clean completion.
- `ST_ECC`: examines one sub-buffer per cycle. It goes to `ST_SCAN` on an uncorrectable count and back to `ST_IDLE` after the last acceptable count.
- `ST_SCAN`: reads the page back. It goes to `ST_HALT` on a byte that is not 0xFF and to `ST_IDLE` when the page is fully erased.
- `ST_HALT`: stays there until reset.

## Requirements
- R1: After reset, `done`, `page_good`, `page_blank`, `fatal_tmo`, `fatal_ecc`, `rd_en` and `evt_wr_en` are all 0.
- R2: After `start`, while bit 31 (operation complete) of `evt_stat` is 0, the block reads no page data and raises neither `done` nor a fatal flag, even when bit 30 is set.
- R3: When bit 31 and bit 30 (flash timeout) of `evt_stat` are both set, `fatal_tmo` rises one cycle later. No ECC status is evaluated, no page byte is read, `fatal_ecc` stays 0 and no `done` follows.
- R4: Buffer b, with S sub-buffers per page, owns sub-buffers b*S through b*S+S-1. Sub-buffer k lives in status word k/4, in byte lane k%4. Lane 0 is bits 31:24 and lane 3 is bits 7:0. The error count is the low 4 bits of the lane.
- R5: A count of 0xF is uncorrectable and every other count is acceptable, whatever the upper nibble of the lane holds. When all counts of the page are acceptable, `done` pulses together with `page_good`=1 and `page_blank`=0, S+1 cycles after the `start` cycle when the event word is already complete.
- R6: On the first uncorrectable sub-buffer, the page is read at `rd_addr` = {b, offset}. The offset runs 0, 1, 2, ... with one read per cycle, and `rd_data` returns one cycle after the read.
- R7: If every byte of the page is 0xFF, `done` pulses with `page_blank`=1 and `page_good`=0, and no later sub-buffer of the page is examined. With first uncorrectable index j (relative to the page) and P bytes per page, this happens 3+j+P cycles after `start`.
- R8: If a page byte at offset n is not 0xFF, `fatal_ecc` rises 4+j+n cycles after `start` and no `done` is issued. Reading stops at most one byte past n.
- R9: Once set, `fatal_tmo` and `fatal_ecc` stay set until reset. Later `start` pulses cause no `done` and no reads.
- R10: In the cycle of `done`, `evt_wr_en` is 1 and `evt_wr_data` equals the `evt_stat` value sampled when completion was seen.
- R11: `page_good` and `page_blank` hold their verdict after `done` until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin checking the page in buffer `buf_sel` |
| buf_sel | input | BUF_W | Page buffer slot number |
| evt_stat | input | 32 | Controller event status word (bit 31 complete, bit 30 timeout) |
| evt_wr_en | output | 1 | Write-back strobe for clearing the event word |
| evt_wr_data | output | 32 | Captured event value to write back |
| ecc_word_sel | output | WSEL_W | Index of the ECC status word being read |
| ecc_word | input | 32 | Selected ECC status word (combinational read) |
| rd_en | output | 1 | Page buffer byte read request |
| rd_addr | output | ADDR_W | Page buffer byte address {slot, offset} |
| rd_data | input | 8 | Read byte, valid one cycle after `rd_en` |
| done | output | 1 | One-cycle completion strobe |
| page_good | output | 1 | Verdict: all sub-buffers acceptable |
| page_blank | output | 1 | Verdict: erased page |
| fatal_tmo | output | 1 | Sticky flash-timeout error |
| fatal_ecc | output | 1 | Sticky uncorrectable-ECC error |

## Verification
Each verdict has a fixed latency counted from the `start` edge:
- a good page finishes S+1 cycles after `start`;
- a blank page finishes 3+j+P cycles after `start`;
- a dirty page raises `fatal_ecc` 4+j+n cycles after `start`;
- a timeout raises `fatal_tmo` one cycle after `start`.

The bench drives inputs on falling edges and counts falling edges from the `start` edge up to the first one at which a result flag appears. It compares that count with the formula, so a result that is one cycle early or late fails the check. The number of page reads and their address sequence are counted at the same clock edges the buffer model uses, and are compared with the predicted values P or min(n+2, P).

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;
    // Event status bit positions that the controller defines
    localparam int EVT_DONE_BIT = 31;
    localparam int EVT_TMO_BIT  = 30;
    // Status word packing
    localparam int LANES_PER_WORD = 4;
    localparam logic [3:0] CNT_UNCORR = 4'hF;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_ECC,
        ST_SCAN,
        ST_HALT
    } chk_state_e;
endpackage

// File: rtl/ecc_lane_pick.sv
module ecc_lane_pick
    import pgchk_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    output logic        uncorr
);
    logic [3:0] lane_cnt [LANES_PER_WORD];

    // Lane 0 lives in the most significant byte; count is its low nibble
    for (genvar g = 0; g < LANES_PER_WORD; g++) begin : g_lane
        assign lane_cnt[g] = word[24 - 8*g +: 4];
    end

    assign uncorr = (lane_cnt[lane] == CNT_UNCORR);
endmodule

// File: rtl/page_blank_scan.sv
module page_blank_scan
    import pgchk_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       rd_data,
    output logic             rd_en,
    output logic [OFF_W-1:0] rd_off,
    output logic             scan_dirty,
    output logic             scan_blank
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    logic             issuing;
    logic             vld;
    logic             last_q;
    logic [OFF_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            vld     <= 1'b0;
            last_q  <= 1'b0;
            cnt     <= '0;
        end else if (go) begin
            issuing <= 1'b1;
            vld     <= 1'b0;
            last_q  <= 1'b0;
            cnt     <= '0;
        end else if (scan_dirty) begin
            issuing <= 1'b0;
            vld     <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            vld    <= issuing;
            last_q <= issuing && (cnt == LAST_OFF);
            if (issuing) begin
                if (cnt == LAST_OFF) begin
                    issuing <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign rd_en      = issuing;
    assign rd_off     = cnt;
    assign scan_dirty = vld && (rd_data != ERASED_BYTE);
    assign scan_blank = vld && last_q && (rd_data == ERASED_BYTE);

    // R6: consecutive reads step the offset by one
    assert_scan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && !$past(go)) |-> (rd_off == $past(rd_off) + 1'b1));

    // R8: a dirty byte halts the read stream at the next cycle
    assert_scan_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_dirty |=> !rd_en);

    // R7: verdicts are exclusive
    assert_scan_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_dirty && scan_blank));
endmodule

// File: rtl/nand_page_ecc_check.sv
module nand_page_ecc_check
    import pgchk_pkg::*;
#(
    parameter int SUB_BYTES     = 512,
    parameter int SUBS_PER_PAGE = 4,
    parameter int ECC_WORDS     = 4,
    localparam int PAGE_BYTES = SUB_BYTES * SUBS_PER_PAGE,
    localparam int TOTAL_SUBS = ECC_WORDS * LANES_PER_WORD,
    localparam int NUM_BUFS   = TOTAL_SUBS / SUBS_PER_PAGE,
    localparam int BUF_W      = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
    localparam int SUB_W      = $clog2(TOTAL_SUBS),
    localparam int WSEL_W     = $clog2(ECC_WORDS),
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int ADDR_W     = BUF_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUF_W-1:0]  buf_sel,
    input  logic [31:0]       evt_stat,
    output logic              evt_wr_en,
    output logic [31:0]       evt_wr_data,
    output logic [WSEL_W-1:0] ecc_word_sel,
    input  logic [31:0]       ecc_word,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              done,
    output logic              page_good,
    output logic              page_blank,
    output logic              fatal_tmo,
    output logic              fatal_ecc
);
    chk_state_e       state_q, state_d;
    logic [BUF_W-1:0] buf_q;
    logic [SUB_W-1:0] sub_q, last_q;
    logic [SUB_W-1:0] sub_first, sub_last;
    logic [31:0]      evt_q;
    logic             evt_done, evt_tmo;
    logic             lane_uncorr;
    logic             scan_go, scan_dirty, scan_blank;
    logic [OFF_W-1:0] rd_off;

    assign sub_first = SUB_W'(buf_sel) * SUB_W'(SUBS_PER_PAGE);
    assign sub_last  = sub_first + SUB_W'(SUBS_PER_PAGE - 1);
    assign evt_done  = evt_stat[EVT_DONE_BIT];
    assign evt_tmo   = evt_stat[EVT_TMO_BIT];

    assign ecc_word_sel = sub_q[SUB_W-1:2];

    ecc_lane_pick u_lane (
        .word   (ecc_word),
        .lane   (sub_q[1:0]),
        .uncorr (lane_uncorr)
    );

    assign scan_go = (state_q == ST_ECC) && lane_uncorr;

    page_blank_scan #(.PAGE_BYTES(PAGE_BYTES)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (scan_go),
        .rd_data    (rd_data),
        .rd_en      (rd_en),
        .rd_off     (rd_off),
        .scan_dirty (scan_dirty),
        .scan_blank (scan_blank)
    );

    assign rd_addr     = {buf_q, rd_off};
    assign evt_wr_data = evt_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_POLL;
            ST_POLL: begin
                if (evt_done) state_d = evt_tmo ? ST_HALT : ST_ECC;
            end
            ST_ECC: begin
                if (lane_uncorr)          state_d = ST_SCAN;
                else if (sub_q == last_q) state_d = ST_IDLE;
            end
            ST_SCAN: begin
                if (scan_dirty)      state_d = ST_HALT;
                else if (scan_blank) state_d = ST_IDLE;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q      <= '0;
            sub_q      <= '0;
            last_q     <= '0;
            evt_q      <= '0;
            done       <= 1'b0;
            evt_wr_en  <= 1'b0;
            page_good  <= 1'b0;
            page_blank <= 1'b0;
            fatal_tmo  <= 1'b0;
            fatal_ecc  <= 1'b0;
        end else begin
            done      <= 1'b0;
            evt_wr_en <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        buf_q      <= buf_sel;
                        sub_q      <= sub_first;
                        last_q     <= sub_last;
                        page_good  <= 1'b0;
                        page_blank <= 1'b0;
                    end
                end
                ST_POLL: begin
                    if (evt_done) begin
                        evt_q <= evt_stat;
                        if (evt_tmo) fatal_tmo <= 1'b1;
                    end
                end
                ST_ECC: begin
                    if (!lane_uncorr) begin
                        if (sub_q == last_q) begin
                            done      <= 1'b1;
                            page_good <= 1'b1;
                            evt_wr_en <= 1'b1;
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                end
                ST_SCAN: begin
                    if (scan_dirty) begin
                        fatal_ecc <= 1'b1;
                    end else if (scan_blank) begin
                        done       <= 1'b1;
                        page_blank <= 1'b1;
                        evt_wr_en  <= 1'b1;
                    end
                end
                ST_HALT: ;
                default: ;
            endcase
        end
    end

    // R10: write-back accompanies completion and carries the complete bit
    assert_wb_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (evt_wr_en && evt_wr_data[EVT_DONE_BIT]));

    // R5: exactly one verdict at completion
    assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({page_good, page_blank}) == 1));

    // R9: fatal flags are sticky
    assert_ecc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_ecc |=> fatal_ecc);
    assert_tmo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_tmo |=> fatal_tmo);

    // R8: nothing is read or reported after a fatal error
    assert_quiet_after_fatal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_ecc || fatal_tmo) |-> (!rd_en && !done));

    // R3: a timeout excludes ECC evaluation
    assert_tmo_no_ecc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_tmo |-> !fatal_ecc);

    // R2: no page reads while waiting on the event word
    assert_no_read_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> !rd_en);
endmodule

// File: tb/tb_nand_page_ecc_check.sv
`timescale 1ns/1ps
module tb_nand_page_ecc_check;
    localparam int SB = 8, SPP = 2, EW = 2;
    localparam int PB = SB * SPP;
    localparam int NB = EW * 4 / SPP;

    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [1:0]  buf_sel;
    logic [31:0] evt_stat, evt_wr_data, ecc_word;
    logic        evt_wr_en, rd_en, done, page_good, page_blank, fatal_tmo, fatal_ecc;
    logic [0:0]  ecc_word_sel;
    logic [5:0]  rd_addr;
    logic [7:0]  rd_data;

    logic [31:0] ecc_regs [EW];
    logic [7:0]  ram [NB*PB];

    int total = 0, bad = 0;
    int reads = 0, bad_addr = 0, rd_base = 0, cur_buf = 0;

    always #2.5 clk = ~clk;

    nand_page_ecc_check #(.SUB_BYTES(SB), .SUBS_PER_PAGE(SPP), .ECC_WORDS(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_sel(buf_sel),
        .evt_stat(evt_stat), .evt_wr_en(evt_wr_en), .evt_wr_data(evt_wr_data),
        .ecc_word_sel(ecc_word_sel), .ecc_word(ecc_word),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .page_good(page_good), .page_blank(page_blank),
        .fatal_tmo(fatal_tmo), .fatal_ecc(fatal_ecc)
    );

    assign ecc_word = ecc_regs[ecc_word_sel];

    // Buffer RAM model plus read monitor
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= ram[rd_addr];
            if (int'(rd_addr[5:4]) != cur_buf || int'(rd_addr[3:0]) != reads - rd_base)
                bad_addr = bad_addr + 1;
            reads = reads + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; buf_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic setup(input int b, input logic [3:0] c0, input logic [3:0] c1, input int dirty);
        for (int a = 0; a < NB*PB; a++) ram[a] = (a / PB == b) ? 8'hFF : 8'h00;
        if (dirty >= 0) ram[b*PB + dirty] = 8'h7E;
        for (int w = 0; w < EW; w++) ecc_regs[w] = 32'h0F0F_0F0F;
        for (int i = 0; i < SPP; i++) begin
            int k = b*SPP + i;
            ecc_regs[k/4][24 - 8*(k%4) +: 8] = (i == 0) ? {4'h6, c0} : {4'h9, c1};
        end
        cur_buf = b;
        rd_base = reads;
        bad_addr = 0;
    endtask

    task automatic pulse_start(input int b);
        @(negedge clk);
        buf_sel = 2'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_result(output int lat);
        lat = 0;
        while (lat < 80) begin
            @(negedge clk);
            lat++;
            if (done || fatal_ecc || fatal_tmo) break;
        end
    endtask

    task automatic sweep_case(input int b, input logic [3:0] c0, input logic [3:0] c1, input int dirty);
        int lat, j, exp_lat, exp_reads;
        bit wen; logic [31:0] wdat, ev;
        do_reset();
        setup(b, c0, c1, dirty);
        ev = 32'h8000_0000 | (32'h11 * (b + 1));
        evt_stat = ev;
        pulse_start(b);
        wait_result(lat);
        wen = evt_wr_en; wdat = evt_wr_data;
        j = (c0 == 4'hF) ? 0 : ((c1 == 4'hF) ? 1 : -1);
        if (j < 0) begin
            chk("R5", "good latency", lat, SPP + 1);
            chk("R5", "good flag", page_good, 1);
            chk("R4", "blank flag", page_blank, 0);
            chk("R4", "no reads", reads - rd_base, 0);
            chk("R10", "writeback en", wen, 1);
            chk("R10", "writeback data", wdat, ev);
        end else if (dirty < 0) begin
            exp_lat = 3 + j + PB;
            chk("R7", "blank latency", lat, exp_lat);
            chk("R7", "blank flag", page_blank, 1);
            chk("R7", "good flag", page_good, 0);
            chk("R6", "read count", reads - rd_base, PB);
            chk("R6", "read addresses", bad_addr, 0);
            chk("R10", "writeback data", wen ? wdat : 32'h0, ev);
        end else begin
            exp_lat = 4 + j + dirty;
            exp_reads = (dirty + 2 < PB) ? dirty + 2 : PB;
            chk("R8", "fatal latency", lat, exp_lat);
            chk("R8", "fatal_ecc", fatal_ecc, 1);
            chk("R8", "done", done, 0);
            chk("R8", "read count", reads - rd_base, exp_reads);
            chk("R6", "read addresses", bad_addr, 0);
        end
        if (done) begin
            repeat (3) @(negedge clk);
            chk("R11", "verdict held", {page_good, page_blank}, (j < 0) ? 2 : 1);
            pulse_start(b);
            chk("R11", "verdict cleared", {page_good, page_blank}, 0);
        end else begin
            int saw_done = 0;
            int r0 = reads;
            pulse_start(b);
            repeat (30) begin
                @(negedge clk);
                if (done) saw_done++;
            end
            chk("R9", "fatal_ecc sticky", fatal_ecc, 1);
            chk("R9", "done after fatal", saw_done, 0);
            chk("R9", "reads after fatal", reads - r0, 0);
        end
    endtask

    initial begin
        logic [3:0] codes [3];
        int dl [4];
        int lat;
        codes[0] = 4'h0; codes[1] = 4'h7; codes[2] = 4'hF;
        dl[0] = -1; dl[1] = 0; dl[2] = 9; dl[3] = 15;
        evt_stat = 32'h0;
        for (int w = 0; w < EW; w++) ecc_regs[w] = '0;
        for (int a = 0; a < NB*PB; a++) ram[a] = 8'hFF;

        // R1: reset state
        do_reset();
        chk("R1", "outputs after reset",
            {done, page_good, page_blank, fatal_tmo, fatal_ecc, rd_en, evt_wr_en}, 0);

        // R2: polling holds off while the complete bit is clear
        setup(2, 4'h0, 4'h0, -1);
        evt_stat = 32'h4000_0000;
        pulse_start(2);
        begin
            int seen = 0;
            repeat (6) begin
                @(negedge clk);
                if (done || fatal_tmo || fatal_ecc || rd_en) seen++;
            end
            chk("R2", "activity while polling", seen, 0);
        end
        evt_stat = 32'h8000_0042;
        wait_result(lat);
        chk("R2", "latency after complete", lat, 3);
        chk("R10", "writeback after poll", evt_wr_data, 32'h8000_0042);

        // R3: timeout pre-empts ECC evaluation
        do_reset();
        setup(1, 4'hF, 4'hF, 3);
        evt_stat = 32'hC000_0003;
        pulse_start(1);
        wait_result(lat);
        chk("R3", "timeout latency", lat, 1);
        chk("R3", "fatal_tmo", fatal_tmo, 1);
        repeat (10) @(negedge clk);
        chk("R3", "fatal_ecc after timeout", fatal_ecc, 0);
        chk("R3", "reads after timeout", reads - rd_base, 0);
        chk("R9", "fatal_tmo sticky", fatal_tmo, 1);

        // R4..R8: sweep over slots, codes and data patterns
        for (int b = 0; b < NB; b++)
            for (int x = 0; x < 3; x++)
                for (int y = 0; y < 3; y++)
                    for (int d = 0; d < 4; d++) begin
                        if ((codes[x] != 4'hF && codes[y] != 4'hF) && d != 0) continue;
                        sweep_case(b, codes[x], codes[y], dl[d]);
                    end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule